// File: doc/BRIEF.md
# Push-On/Push-Off Power Sequencer

This block is the power on/off controller of a multi-rail supply chip. A momentary low on the ON button wakes the device from shutdown and turns on the main rail. The block then holds the host's reset line low until the main rail has been in regulation for a programmed hold time. Once reset is released, the host must confirm that it is alive by raising the OFF hold input before a watchdog window runs out. If it does not, the whole device shuts down. After power-up the button level is echoed to the host so that a later press can be read as an off request.

The host can also turn the device off through the register bank by disabling the main rail (soft-off). A main-rail dropout pulls reset low again and restarts the hold time. An optional shutdown timer turns everything off if the rail stays out of regulation for too long. All time windows are counted in ticks of a millisecond strobe. ON and OFF are synchronised and debounced before the state machine sees them. A one-cycle power-on-reset pulse tells the register bank to load its defaults after supply reset.

Top module: `pwr_seq_top`

## Requirements
- R1: From shutdown, a debounced low on `on_btn_n` raises `main_rail_en` within DEB_TICKS to DEB_TICKS+1 ticks with `rst_out_n` still low. The rail stays on after the button is released.
- R2: `rst_out_n` rises only after `rail_good` has been high for RST_TICKS consecutive ticks (to within one tick), and only in a cycle that follows one where `rail_good` was high.
- R3: While running with the button released, OFF hold low for WDOG_TICKS ticks shuts the device down. A high OFF hold within the window keeps it on.
- R4: While the debounced button is held low, OFF hold is ignored and the main rail and reset stay up.
- R5: `on_echo` is 1 until the first power-up. After that it equals the debounced level of `on_btn_n`.
- R6: A low `rail_good` while running drives `rst_out_n` low on the next clock edge. While the rail is out of regulation and during the following hold time, the watchdog does not count.
- R7: `soft_off` high while powered gives shutdown on the next clock edge. After any shutdown, only a new button press (a debounced high-to-low change) powers up again.
- R8: With SDT_EN=1, `rail_good` low continuously for SDT_TICKS ticks while reset is held and the button is released shuts the device down. Any recovery of `rail_good` restarts that count from zero.
- R9: In shutdown, `pwr_down`=1, `main_rail_en`=0 and `rst_out_n`=0.
- R10: A button low shorter than DEB_TICKS ticks has no effect. The device stays in shutdown.
- R11: `por_pulse` is high for exactly one cycle, on the first clock edge after `rst` is released.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high supply reset |
| tick_ms | input | 1 | One-cycle time-base strobe |
| on_btn_n | input | 1 | Active-low ON button, asynchronous |
| off_hold | input | 1 | Host keep-alive level, asynchronous |
| rail_good | input | 1 | Main rail in regulation flag |
| soft_off | input | 1 | Register-bank request to disable the main rail |
| main_rail_en | output | 1 | Main rail enable |
| rst_out_n | output | 1 | Active-low host reset |
| on_echo | output | 1 | Debounced button level echo |
| pwr_down | output | 1 | Global shutdown: clears rail enables, tri-states drivers, stops the port |
| por_pulse | output | 1 | One-cycle register-bank default load |

## Verification
The assertions assume that `tick_ms` is a single-cycle strobe and that `rail_good` and `soft_off` are already synchronous to `clk`. They also assume that no request arrives in the reset cycle itself. The stimulus drives every input at the falling edge, issues a tick every fourth cycle and pulses `soft_off` for one cycle. Glitches on the asynchronous inputs are kept shorter than one tick when their rejection is tested.

// File: rtl/pwr_seq_pkg.sv
`timescale 1ns/1ps
package pwr_seq_pkg;

    typedef enum logic [1:0] {
        PS_OFF  = 2'd0,
        PS_HOLD = 2'd1,
        PS_RUN  = 2'd2
    } pwr_state_e;

    // Counter width able to hold values 0 .. lim-1.
    function automatic int unsigned cnt_w(input int unsigned lim);
        return (lim < 2) ? 1 : $clog2(lim);
    endfunction

endpackage

// File: rtl/pwr_tick_count.sv
`timescale 1ns/1ps
module pwr_tick_count #(
    parameter int unsigned LIMIT = 4
) (
    input  logic clk,
    input  logic rst,
    input  logic clr,
    input  logic adv,
    output logic hit
);
    localparam int unsigned W = pwr_seq_pkg::cnt_w(LIMIT);

    logic [W-1:0] cnt;

    // hit marks the advance that completes LIMIT counted ticks
    assign hit = adv && (cnt == W'(LIMIT - 1));

    always_ff @(posedge clk) begin
        if (rst || clr)
            cnt <= '0;
        else if (adv)
            cnt <= hit ? '0 : cnt + 1'b1;
    end
endmodule

// File: rtl/pwr_debounce.sv
`timescale 1ns/1ps
module pwr_debounce #(
    parameter int unsigned DEB_TICKS = 2,
    parameter bit          IDLE_VAL  = 1'b1
) (
    input  logic clk,
    input  logic rst,
    input  logic tick,
    input  logic raw,
    output logic level
);
    logic s1, s2, differ, flip;

    always_ff @(posedge clk) begin
        if (rst) begin
            s1 <= IDLE_VAL;
            s2 <= IDLE_VAL;
        end else begin
            s1 <= raw;
            s2 <= s1;
        end
    end

    assign differ = (s2 != level);

    pwr_tick_count #(.LIMIT(DEB_TICKS)) u_cnt (
        .clk (clk),
        .rst (rst),
        .clr (!differ),
        .adv (tick && differ),
        .hit (flip)
    );

    always_ff @(posedge clk) begin
        if (rst)
            level <= IDLE_VAL;
        else if (flip)
            level <= s2;
    end
endmodule

// File: rtl/pwr_seq_top.sv
`timescale 1ns/1ps
module pwr_seq_top
    import pwr_seq_pkg::*;
#(
    parameter int unsigned DEB_TICKS  = 8,
    parameter int unsigned RST_TICKS  = 140,
    parameter int unsigned WDOG_TICKS = 35,
    parameter int unsigned SDT_TICKS  = 175,
    parameter bit          SDT_EN     = 1'b1
) (
    input  logic clk,
    input  logic rst,
    input  logic tick_ms,
    input  logic on_btn_n,
    input  logic off_hold,
    input  logic rail_good,
    input  logic soft_off,
    output logic main_rail_en,
    output logic rst_out_n,
    output logic on_echo,
    output logic pwr_down,
    output logic por_pulse
);
    pwr_state_e state, state_nx;
    logic on_lvl, on_prev, off_lvl, press;
    logic ever_on, por_arm;
    logic hold_cond, wd_cond;
    logic hold_hit, wd_hit, sd_hit;

    pwr_debounce #(.DEB_TICKS(DEB_TICKS), .IDLE_VAL(1'b1)) u_on_deb (
        .clk(clk), .rst(rst), .tick(tick_ms), .raw(on_btn_n), .level(on_lvl)
    );
    pwr_debounce #(.DEB_TICKS(DEB_TICKS), .IDLE_VAL(1'b0)) u_off_deb (
        .clk(clk), .rst(rst), .tick(tick_ms), .raw(off_hold), .level(off_lvl)
    );

    // new press = debounced button goes from released to pressed
    assign press = on_prev && !on_lvl;

    // reset hold timer counts only while the rail is good in HOLD
    assign hold_cond = (state == PS_HOLD) && rail_good;
    pwr_tick_count #(.LIMIT(RST_TICKS)) u_hold (
        .clk(clk), .rst(rst), .clr(!hold_cond),
        .adv(tick_ms && hold_cond), .hit(hold_hit)
    );

    // watchdog counts only when running, OFF low and button released
    assign wd_cond = (state == PS_RUN) && !off_lvl && on_lvl;
    pwr_tick_count #(.LIMIT(WDOG_TICKS)) u_wdog (
        .clk(clk), .rst(rst), .clr(!wd_cond),
        .adv(tick_ms && wd_cond), .hit(wd_hit)
    );

    generate
        if (SDT_EN) begin : g_sdt
            logic sd_cond;
            assign sd_cond = (state == PS_HOLD) && !rail_good && on_lvl;
            pwr_tick_count #(.LIMIT(SDT_TICKS)) u_sdt (
                .clk(clk), .rst(rst), .clr(!sd_cond),
                .adv(tick_ms && sd_cond), .hit(sd_hit)
            );
        end else begin : g_no_sdt
            assign sd_hit = 1'b0;
        end
    endgenerate

    always_comb begin
        state_nx = state;
        unique case (state)
            PS_OFF:  if (press) state_nx = PS_HOLD;
            PS_HOLD: begin
                if (soft_off || sd_hit) state_nx = PS_OFF;
                else if (hold_hit)      state_nx = PS_RUN;
            end
            PS_RUN: begin
                if (soft_off)        state_nx = PS_OFF;
                else if (!rail_good) state_nx = PS_HOLD;
                else if (wd_hit)     state_nx = PS_OFF;
            end
            default: state_nx = PS_OFF;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state     <= PS_OFF;
            on_prev   <= 1'b1;
            ever_on   <= 1'b0;
            por_arm   <= 1'b1;
            por_pulse <= 1'b0;
        end else begin
            state     <= state_nx;
            on_prev   <= on_lvl;
            ever_on   <= ever_on || (state_nx != PS_OFF);
            por_arm   <= 1'b0;
            por_pulse <= por_arm;
        end
    end

    assign main_rail_en = (state != PS_OFF);
    assign rst_out_n    = (state == PS_RUN);
    assign pwr_down     = (state == PS_OFF);
    assign on_echo      = ever_on ? on_lvl : 1'b1;
endmodule

// File: rtl/pwr_seq_chk.sv
`timescale 1ns/1ps
module pwr_seq_chk (
    input logic clk,
    input logic rst,
    input logic rail_good,
    input logic soft_off,
    input logic main_rail_en,
    input logic rst_out_n,
    input logic pwr_down,
    input logic por_pulse
);
    // R9: shutdown state forces rail off and reset low
    a_r9_down_outputs: assert property (@(posedge clk) disable iff (rst)
        pwr_down |-> (!main_rail_en && !rst_out_n));

    // R6: loss of regulation while released drops reset next edge
    a_r6_rail_drop: assert property (@(posedge clk) disable iff (rst)
        (rst_out_n && !rail_good) |=> !rst_out_n);

    // R2: reset release always follows a cycle with the rail good
    a_r2_release_rail_good: assert property (@(posedge clk) disable iff (rst)
        $rose(rst_out_n) |-> $past(rail_good));

    // R7: soft-off while powered shuts down on the next edge
    a_r7_soft_off: assert property (@(posedge clk) disable iff (rst)
        (soft_off && !pwr_down) |=> pwr_down);

    // R1: leaving shutdown always starts with reset held
    a_r1_start_in_reset: assert property (@(posedge clk) disable iff (rst)
        $fell(pwr_down) |-> !rst_out_n);

    // R11: power-on-reset pulse lasts one cycle
    a_r11_por_single: assert property (@(posedge clk) disable iff (rst)
        por_pulse |=> !por_pulse);
endmodule

bind pwr_seq_top pwr_seq_chk u_chk (
    .clk          (clk),
    .rst          (rst),
    .rail_good    (rail_good),
    .soft_off     (soft_off),
    .main_rail_en (main_rail_en),
    .rst_out_n    (rst_out_n),
    .pwr_down     (pwr_down),
    .por_pulse    (por_pulse)
);

// File: tb/pwr_seq_top_tb.sv
`timescale 1ns/1ps
module pwr_seq_top_tb;
    localparam int DEB = 2;
    localparam int RST = 5;
    localparam int WD  = 4;
    localparam int SD  = 7;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic tick = 1'b0;
    logic on_n = 1'b1;
    logic off_hold = 1'b0;
    logic rail_good = 1'b0;
    logic soft_off = 1'b0;
    logic rail_en, rst_n, ono, down, por;

    int total = 0;
    int bad = 0;
    int tcnt = 0;
    int ph = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    pwr_seq_top #(
        .DEB_TICKS(DEB), .RST_TICKS(RST), .WDOG_TICKS(WD),
        .SDT_TICKS(SD), .SDT_EN(1'b1)
    ) u_dut (
        .clk(clk), .rst(rst), .tick_ms(tick), .on_btn_n(on_n),
        .off_hold(off_hold), .rail_good(rail_good), .soft_off(soft_off),
        .main_rail_en(rail_en), .rst_out_n(rst_n), .on_echo(ono),
        .pwr_down(down), .por_pulse(por)
    );

    always @(negedge clk) begin
        ph   = (ph + 1) % 4;
        tick = (ph == 0);
    end

    always @(posedge clk) if (!rst && tick) tcnt++;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic report();
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    endtask

    function automatic bit probe(input int k);
        case (k)
            0:       return rail_en;
            1:       return rst_n;
            default: return down;
        endcase
    endfunction

    task automatic ticks(input int n);
        int s = tcnt;
        while (tcnt - s < n) @(negedge clk);
    endtask

    task automatic count_until(input int k, input bit v, input int maxt, output int n);
        int s = tcnt;
        while (probe(k) != v && (tcnt - s) <= maxt + 2) @(negedge clk);
        n = tcnt - s;
    endtask

    task automatic press_on();
        int n;
        on_n = 1'b0;
        count_until(0, 1'b1, DEB + 3, n);
        chk(rail_en && n >= DEB && n <= DEB + 1, "R1 power-up latency", n, DEB);
        chk(!rst_n, "R1 reset low at power-up", rst_n, 0);
    endtask

    task automatic set_off(input bit v);
        off_hold = v;
        ticks(DEB + 2);
    endtask

    task automatic to_run();
        int n;
        set_off(1'b1);
        press_on();
        on_n = 1'b1;
        rail_good = 1'b1;
        count_until(1, 1'b1, RST + 3, n);
        chk(rst_n && n <= RST + 1, "R2 reach run", n, RST);
        ticks(DEB + 1);
    endtask

    initial begin
        int n;
        void'($urandom(32'd4711));
        @(negedge clk); @(negedge clk);
        @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R11 pulse and reset state
        chk(por == 1'b1, "R11 por high first cycle", por, 1);
        chk(down && !rail_en && !rst_n, "R9 reset state down", down, 1);
        chk(ono == 1'b1, "R5 echo high before power-up", ono, 1);
        @(negedge clk);
        chk(por == 1'b0, "R11 por single cycle", por, 0);

        // R10: glitch shorter than debounce
        on_n = 1'b0;
        repeat (3) @(negedge clk);
        on_n = 1'b1;
        ticks(4 * DEB);
        chk(!rail_en && down, "R10 glitch ignored", rail_en, 0);
        chk(ono == 1'b1, "R5 echo still high", ono, 1);

        // R1, R5, R2
        set_off(1'b1);
        press_on();
        ticks(DEB + 2);
        chk(ono == 1'b0, "R5 echo follows pressed", ono, 0);
        on_n = 1'b1;
        ticks(DEB + 2);
        chk(ono == 1'b1, "R5 echo follows released", ono, 1);
        chk(rail_en == 1'b1, "R1 stays on after release", rail_en, 1);
        rail_good = 1'b1;
        count_until(1, 1'b1, RST + 3, n);
        chk(rst_n && (n == RST || n == RST + 1), "R2 reset hold window", n, RST);

        // R3: OFF high keeps it on
        ticks(3 * WD);
        chk(rail_en && rst_n, "R3 off high keeps on", rail_en, 1);

        // R3: OFF dropped -> shutdown after debounce + window
        off_hold = 1'b0;
        count_until(2, 1'b1, DEB + WD + 3, n);
        chk(down && (n == DEB + WD || n == DEB + WD + 1), "R3 watchdog expiry", n, DEB + WD);
        chk(!rail_en && !rst_n, "R9 down outputs", rail_en, 0);

        // R3 exact window from reset release, OFF low throughout
        press_on();
        on_n = 1'b1;
        count_until(1, 1'b1, RST + 3, n);
        chk(rst_n == 1'b1, "R2 release with off low", rst_n, 1);
        count_until(2, 1'b1, WD + 3, n);
        chk(down && (n == WD || n == WD + 1), "R3 window from release", n, WD);

        // R4: button held ignores OFF
        press_on();
        ticks(RST + 3 * WD);
        chk(rail_en && rst_n, "R4 held button keeps on", rst_n, 1);
        chk(ono == 1'b0, "R5 echo low while held", ono, 0);
        on_n = 1'b1;
        count_until(2, 1'b1, DEB + WD + 3, n);
        chk(down && n >= DEB + WD && n <= DEB + WD + 1, "R3 after release", n, DEB + WD);

        // R7: ON still released -> no restart
        ticks(10);
        chk(down == 1'b1, "R7 no restart without press", down, 1);

        // R6 and R8
        to_run();
        rail_good = 1'b0;
        @(negedge clk);
        chk(rst_n == 1'b0, "R6 reset drops next edge", rst_n, 0);
        off_hold = 1'b0;
        ticks(WD + 1);
        chk(rail_en == 1'b1, "R6 watchdog idle during dropout", rail_en, 1);
        rail_good = 1'b1;
        ticks(1);
        rail_good = 1'b0;
        count_until(2, 1'b1, SD + 3, n);
        chk(down && (n == SD || n == SD + 1), "R8 shutdown timer restart", n, SD);
        chk(!rail_en && !rst_n, "R9 down after timer", rail_en, 0);

        // R6 recovery hold
        to_run();
        rail_good = 1'b0;
        ticks(2);
        rail_good = 1'b1;
        count_until(1, 1'b1, RST + 3, n);
        chk(rst_n && (n == RST || n == RST + 1), "R6 hold after recovery", n, RST);

        // R7 soft-off
        soft_off = 1'b1;
        @(negedge clk);
        soft_off = 1'b0;
        chk(down == 1'b1, "R7 soft off next edge", down, 1);
        ticks(6);
        chk(down == 1'b1, "R7 stays off", down, 1);

        // random rail delays before regulation
        for (int i = 0; i < 6; i++) begin
            int d;
            d = $urandom_range(0, 3);
            set_off(1'b1);
            rail_good = 1'b0;
            press_on();
            on_n = 1'b1;
            ticks(d);
            rail_good = 1'b1;
            count_until(1, 1'b1, RST + 3, n);
            chk(rst_n && (n == RST || n == RST + 1), "R2 random rail delay", n, RST);
            soft_off = 1'b1;
            @(negedge clk);
            soft_off = 1'b0;
            chk(down == 1'b1, "R7 random soft off", down, 1);
            ticks(DEB + 2);
        end

        done = 1'b1;
        report();
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog: actual=%0d expected=%0d", 0, 1);
            report();
        end
    end
endmodule